// File: doc/BRIEF.md
# SD Card Clock Divider and DAT Timeout Controller

This block derives the card clock from the base clock and supervises the data line for a host controller. Software programs one 32-bit control word that holds an internal clock enable, a card clock enable, an eight-bit divisor code, a four-bit timeout exponent and three self-clearing reset requests. The divided card clock appears as a one-cycle strobe in the base clock domain, `sdclk_tick_o`, marking each card clock rising edge. A downstream clock gate or the line engines consume this strobe. The strobe runs only after a warm-up delay following the internal enable, and only while the card clock enable is set.

A timeout counter watches the DAT line while `dat_wait_i` is high and counts pulses of an external timeout clock tick. Every activity pulse on the line restarts the count. When the programmed interval runs out, a one-cycle flag is raised and the counter then idles until it is restarted. The three reset requests each leave the block as a one-cycle pulse. Software uses the all-logic reset to return the clock settings to their idle state.

Top module: `sd_clk_ctrl`

## Requirements
- R1: After reset the read word is zero, and `sdclk_tick_o`, `dat_timeout_o` and all three reset pulses are low.
- R2: Bit 1 of the read word is the stable flag, and writes to bit 1 have no effect. The flag reads 1 exactly `STABLE_CYCLES` clock edges after the edge that sets the internal enable (bit 0). It reads 0 in the cycle after the write that clears bit 0.
- R3: The divisor code in bits 15:8 sets the strobe period in base cycles. Code 0x00 gives 1. A code with only bit k set gives 2^(k+1), so 0x01 gives 2 and 0x80 gives 256.
- R4: A nonzero divisor code with more than one bit set gives a period of 256.
- R5: `sdclk_tick_o` pulses only while the stable flag and the card clock enable (bit 2) are both 1.
- R6: Timeout exponent n in bits 19:16 makes `dat_timeout_o` pulse in the cycle after the 2^(TO_BASE_EXP+n)-th timeout tick since the count restarted. With the default, this is 2^(13+n). Cycles without a tick do not advance the count.
- R7: Exponent code 15 behaves as the largest legal code, 14, which gives 2^(TO_BASE_EXP+14) ticks.
- R8: `dat_timeout_o` is high for one cycle. After it, the counter stays idle until `dat_wait_i` falls or `dat_act_i` pulses. A `dat_act_i` pulse restarts the count from zero.
- R9: A write with bit 24, 25 or 26 set produces a one-cycle pulse on `rst_all_o`, `rst_cmd_o` or `rst_dat_o` respectively. The pulse appears in the cycle after the write edge. The written bit reads 1 for that cycle only.
- R10: A write with bit 24 set clears the internal enable, the card clock enable and the divisor code, whatever their written values. The timeout exponent takes the written value.
- R11: An all-logic or DAT reset pulse restarts the timeout count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Control word read data |
| tmclk_tick_i | input | 1 | Timeout clock tick, one cycle per timeout clock period |
| dat_wait_i | input | 1 | High while a DAT line response is awaited; arms the timeout |
| dat_act_i | input | 1 | DAT line activity pulse; restarts the timeout count |
| sdclk_tick_o | output | 1 | One-cycle strobe per card clock rising edge |
| dat_timeout_o | output | 1 | One-cycle DAT timeout flag |
| rst_all_o | output | 1 | One-cycle all-logic software reset pulse |
| rst_cmd_o | output | 1 | One-cycle CMD line software reset pulse |
| rst_dat_o | output | 1 | One-cycle DAT line software reset pulse |

## Verification
The assertions check properties on every cycle. A card clock strobe never appears without both enables and the stable flag. The stable flag never stands without the internal enable and rises only after it. Timeout and reset pulses last one cycle and trace back to a write or an armed wait. An all-logic reset pulse always coincides with cleared clock fields. The exact strobe period for each divisor code, the warm-up length, and the tick count to expiry for each exponent depend on counting over long windows, so only the bench scenarios show them. The same holds for the saturation of the reserved code and the restart by activity or DAT reset.

// File: rtl/sd_clk_pkg.sv
package sd_clk_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned INT_EN_B  = 0;
  localparam int unsigned STABLE_B  = 1;
  localparam int unsigned SD_EN_B   = 2;
  localparam int unsigned DIV_LSB   = 8;
  localparam int unsigned DIV_W     = 8;
  localparam int unsigned TMO_LSB   = 16;
  localparam int unsigned TMO_W     = 4;
  localparam int unsigned RST_LSB   = 24;
  localparam int unsigned RST_W     = 3;
  // reset pulse index
  localparam int unsigned RST_ALL   = 0;
  localparam int unsigned RST_CMD   = 1;
  localparam int unsigned RST_DAT   = 2;

  typedef struct packed {
    logic             int_en;
    logic             sd_en;
    logic [DIV_W-1:0] div;
    logic [TMO_W-1:0] tmo;
  } clk_cfg_t;

  // Divisor code -> strobe period minus one
  function automatic logic [DIV_W-1:0] div_period_m1(input logic [DIV_W-1:0] code);
    logic [DIV_W-1:0] p;
    p = '1;
    if (code == '0) begin
      p = '0;
    end else if ($countones(code) == 1) begin
      for (int k = 0; k < int'(DIV_W); k++) begin
        if (code[k]) p = DIV_W'((16'd2 << k) - 16'd1);
      end
    end
    return p;
  endfunction
endpackage

// File: rtl/sd_clk_gen.sv
module sd_clk_gen #(
  parameter int unsigned STABLE_CYCLES = 16,
  parameter int unsigned DIV_W         = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             int_en_i,
  input  logic             sd_en_i,
  input  logic [DIV_W-1:0] period_m1_i,
  output logic             stable_o,
  output logic             tick_o
);
  localparam int unsigned SW = $clog2(STABLE_CYCLES + 1);

  logic [SW-1:0]    stab_cnt_q;
  logic [DIV_W-1:0] div_cnt_q;
  logic             run;
  logic             wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            stab_cnt_q <= '0;
    else if (!int_en_i)                     stab_cnt_q <= '0;
    else if (stab_cnt_q != SW'(STABLE_CYCLES)) stab_cnt_q <= stab_cnt_q + 1'b1;
  end

  assign stable_o = int_en_i && (stab_cnt_q == SW'(STABLE_CYCLES));
  assign run      = stable_o && sd_en_i;
  // >= so a shrinking divisor never overruns
  assign wrap     = div_cnt_q >= period_m1_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   div_cnt_q <= '0;
    else if (!run) div_cnt_q <= '0;
    else if (wrap) div_cnt_q <= '0;
    else           div_cnt_q <= div_cnt_q + 1'b1;
  end

  assign tick_o = run && wrap;
endmodule

// File: rtl/sd_dat_timer.sv
module sd_dat_timer #(
  parameter int unsigned BASE_EXP = 13,
  parameter int unsigned MAX_CODE = 14,
  parameter int unsigned TMO_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TMO_W-1:0] tmo_code_i,
  input  logic             tick_i,
  input  logic             wait_i,
  input  logic             restart_i,
  output logic             timeout_o
);
  localparam int unsigned CNT_W = BASE_EXP + MAX_CODE + 1;

  logic [TMO_W-1:0] eff_code;
  logic [CNT_W-1:0] limit_m1;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             to_q;

  assign eff_code = (tmo_code_i > TMO_W'(MAX_CODE)) ? TMO_W'(MAX_CODE) : tmo_code_i;
  assign limit_m1 = (CNT_W'(1) << (BASE_EXP + int'(eff_code))) - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      to_q <= 1'b0;
      if (!wait_i || restart_i) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (tick_i && !done_q) begin
        if (cnt_q >= limit_m1) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
          to_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign timeout_o = to_q;
endmodule

// File: rtl/sd_soft_reset.sv
module sd_soft_reset #(
  parameter int unsigned RST_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [RST_W-1:0] req_i,
  output logic [RST_W-1:0] pulse_o
);
  for (genvar g = 0; g < int'(RST_W); g++) begin : g_req
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= we_i && req_i[g];
    end
    assign pulse_o[g] = q;
  end
endmodule

// File: rtl/sd_clk_ctrl.sv
module sd_clk_ctrl
  import sd_clk_pkg::*;
#(
  parameter int unsigned STABLE_CYCLES = 16,
  parameter int unsigned TO_BASE_EXP   = 13,
  parameter int unsigned TO_MAX_CODE   = 14
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        tmclk_tick_i,
  input  logic        dat_wait_i,
  input  logic        dat_act_i,
  output logic        sdclk_tick_o,
  output logic        dat_timeout_o,
  output logic        rst_all_o,
  output logic        rst_cmd_o,
  output logic        rst_dat_o
);
  clk_cfg_t         cfg_q;
  logic [RST_W-1:0] rst_req;
  logic [RST_W-1:0] rst_pulse;
  logic [DIV_W-1:0] period_m1;
  logic             stable;
  logic             restart;
  logic             unused_wdata;

  assign rst_req = reg_wdata_i[RST_LSB +: RST_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (reg_we_i) begin
      cfg_q.tmo <= reg_wdata_i[TMO_LSB +: TMO_W];
      if (rst_req[RST_ALL]) begin
        cfg_q.int_en <= 1'b0;
        cfg_q.sd_en  <= 1'b0;
        cfg_q.div    <= '0;
      end else begin
        cfg_q.int_en <= reg_wdata_i[INT_EN_B];
        cfg_q.sd_en  <= reg_wdata_i[SD_EN_B];
        cfg_q.div    <= reg_wdata_i[DIV_LSB +: DIV_W];
      end
    end
  end

  assign period_m1 = div_period_m1(cfg_q.div);

  sd_clk_gen #(
    .STABLE_CYCLES(STABLE_CYCLES),
    .DIV_W        (DIV_W)
  ) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .int_en_i   (cfg_q.int_en),
    .sd_en_i    (cfg_q.sd_en),
    .period_m1_i(period_m1),
    .stable_o   (stable),
    .tick_o     (sdclk_tick_o)
  );

  sd_soft_reset #(.RST_W(RST_W)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .req_i  (rst_req),
    .pulse_o(rst_pulse)
  );

  assign restart = dat_act_i | rst_pulse[RST_ALL] | rst_pulse[RST_DAT];

  sd_dat_timer #(
    .BASE_EXP(TO_BASE_EXP),
    .MAX_CODE(TO_MAX_CODE),
    .TMO_W   (TMO_W)
  ) u_tmo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tmo_code_i(cfg_q.tmo),
    .tick_i    (tmclk_tick_i),
    .wait_i    (dat_wait_i),
    .restart_i (restart),
    .timeout_o (dat_timeout_o)
  );

  always_comb begin
    reg_rdata_o                        = '0;
    reg_rdata_o[INT_EN_B]              = cfg_q.int_en;
    reg_rdata_o[STABLE_B]              = stable;
    reg_rdata_o[SD_EN_B]               = cfg_q.sd_en;
    reg_rdata_o[DIV_LSB +: DIV_W]      = cfg_q.div;
    reg_rdata_o[TMO_LSB +: TMO_W]      = cfg_q.tmo;
    reg_rdata_o[RST_LSB +: RST_W]      = rst_pulse;
  end

  assign rst_all_o = rst_pulse[RST_ALL];
  assign rst_cmd_o = rst_pulse[RST_CMD];
  assign rst_dat_o = rst_pulse[RST_DAT];

  assign unused_wdata = ^{reg_wdata_i[31:27], reg_wdata_i[23:20],
                          reg_wdata_i[7:3], reg_wdata_i[1]};
endmodule

// File: rtl/sd_clk_ctrl_chk.sv
module sd_clk_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        dat_wait_i,
  input logic        sdclk_tick_o,
  input logic        dat_timeout_o,
  input logic        rst_all_o,
  input logic        rst_cmd_o,
  input logic        rst_dat_o
);
  // R5
  a_r5_tick_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdclk_tick_o |-> (reg_rdata_o[0] && reg_rdata_o[1] && reg_rdata_o[2]));

  // R2
  a_r2_stable_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[1] |-> reg_rdata_o[0]);

  a_r2_stable_after_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[1]) |-> $past(reg_rdata_o[0]));

  // R8
  a_r8_timeout_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_timeout_o |=> !dat_timeout_o);

  a_r8_idle_no_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dat_wait_i |=> !dat_timeout_o);

  // R9
  a_r9_cmd_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cmd_o |-> $past(reg_we_i && reg_wdata_i[25]));

  a_r9_dat_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_dat_o |-> $past(reg_we_i && reg_wdata_i[26]));

  // R10
  a_r10_all_clears_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_all_o |-> (reg_rdata_o[15:8] == 8'h00 && !reg_rdata_o[0] && !reg_rdata_o[2]));

  // R11
  a_r11_dat_rst_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_dat_o || rst_all_o) |=> !dat_timeout_o);
endmodule

bind sd_clk_ctrl sd_clk_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .dat_wait_i   (dat_wait_i),
  .sdclk_tick_o (sdclk_tick_o),
  .dat_timeout_o(dat_timeout_o),
  .rst_all_o    (rst_all_o),
  .rst_cmd_o    (rst_cmd_o),
  .rst_dat_o    (rst_dat_o)
);

// File: tb/tb_sd_clk_ctrl.sv
`timescale 1ns/1ps
module tb_sd_clk_ctrl;
  localparam int STABLE = 5;
  localparam int BASE   = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tmclk = 1'b0;
  logic        dwait = 1'b0;
  logic        dact = 1'b0;
  logic        tick, tout, r_all, r_cmd, r_dat;

  sd_clk_ctrl #(.STABLE_CYCLES(STABLE), .TO_BASE_EXP(BASE), .TO_MAX_CODE(14)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .tmclk_tick_i(tmclk), .dat_wait_i(dwait),
    .dat_act_i(dact), .sdclk_tick_o(tick), .dat_timeout_o(tout),
    .rst_all_o(r_all), .rst_cmd_o(r_cmd), .rst_dat_o(r_dat)
  );

  always #10 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // shadow of writable fields
  bit       s_int, s_sd;
  bit [7:0] s_div;
  bit [3:0] s_tmo;

  function automatic logic [31:0] pack();
    return {8'h00, 4'h0, s_tmo, s_div, 5'h00, s_sd, 1'b0, s_int};
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  // scoreboard for strobe intervals
  typedef struct { int per; string req; } exp_t;
  exp_t exp_q[$];
  int   last_tick = 0;
  bit   quiet = 0;
  int   stray = 0;

  always @(negedge clk) begin
    if (rst_n && tick) begin
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.per != 0) chk((cyc - last_tick) == e.per, e.req, cyc - last_tick, e.per);
        last_tick = cyc;
      end else if (quiet) begin
        stray++;
      end
    end
  end

  task automatic run_div(input bit [7:0] code, input int per, input string req);
    s_int = 1; s_sd = 1; s_div = code;
    exp_q.push_back('{0, req});
    for (int i = 0; i < 4; i++) exp_q.push_back('{per, req});
    wr(pack());
    for (int c = 0; c < 6 * per + 20 && exp_q.size() > 0; c++) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    s_sd = 0;
    wr(pack());
    exp_q.delete();
  endtask

  task automatic run_to(input int code, input int per, input int act_after,
                        input int exp_ticks, input string req);
    int  issued;
    bit  seen;
    bit  restarted;
    s_tmo = 4'(code);
    wr(pack());
    dwait = 1'b1;
    issued = 0; seen = 0; restarted = 0;
    for (int c = 0; c < exp_ticks * per * 2 + 50 && !seen; c++) begin
      dact = 1'b0; tmclk = 1'b0;
      if (act_after > 0 && !restarted && issued == act_after) begin
        dact = 1'b1; restarted = 1; issued = 0;
      end else if (c % per == 0) begin
        tmclk = 1'b1; issued++;
      end
      @(negedge clk);
      if (tout) seen = 1;
    end
    chk(seen && issued == exp_ticks, req, seen ? issued : -1, exp_ticks);
    tmclk = 1'b0; dact = 1'b0;
    @(negedge clk);
    chk(!tout, "R8", tout, 0);
    tmclk = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!tout, "R8", tout, 0);
    end
    tmclk = 1'b0; dwait = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    s_int = 0; s_sd = 0; s_div = 0; s_tmo = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(rdata == 32'h0, "R1", rdata, 0);
    chk({tick, tout, r_all, r_cmd, r_dat} == 5'b0, "R1",
        {tick, tout, r_all, r_cmd, r_dat}, 0);

    // R2: read-only stable bit
    wr(32'h0000_0002);
    chk(rdata[1] == 1'b0, "R2", rdata[1], 0);

    // R5: card enable without internal enable -> no strobe
    quiet = 1; stray = 0;
    s_int = 0; s_sd = 1; s_div = 8'h00;
    wr(pack());
    repeat (20) @(negedge clk);
    chk(stray == 0, "R5", stray, 0);
    s_sd = 0;
    wr(pack());

    // R2: warm-up timing
    s_int = 1;
    wr(pack());
    repeat (STABLE - 1) @(negedge clk);
    chk(rdata[1] == 1'b0, "R2", rdata[1], 0);
    @(negedge clk);
    chk(rdata[1] == 1'b1, "R2", rdata[1], 1);

    // R5: stable but card enable off
    repeat (20) @(negedge clk);
    chk(stray == 0, "R5", stray, 0);

    // R2: drop on disable
    s_int = 0;
    wr(pack());
    chk(rdata[1] == 1'b0, "R2", rdata[1], 0);
    s_int = 1;
    wr(pack());
    repeat (STABLE + 2) @(negedge clk);
    quiet = 0;

    // R3 / R4
    run_div(8'h00, 1,   "R3");
    run_div(8'h01, 2,   "R3");
    run_div(8'h04, 8,   "R3");
    run_div(8'h20, 64,  "R3");
    run_div(8'h80, 256, "R3");
    run_div(8'h03, 256, "R4");
    run_div(8'hFF, 256, "R4");

    // R6 / R8 / R7
    run_to(0, 1, 0, 2,  "R6");
    run_to(3, 3, 0, 16, "R6");
    run_to(2, 1, 5, 8,  "R8");
    run_to(15, 1, 0, 32768, "R7");

    // R11: DAT reset restarts count
    s_tmo = 4'd2;
    wr(pack());
    dwait = 1'b1; tmclk = 1'b1;
    repeat (5) @(negedge clk);
    tmclk = 1'b0;
    wr(pack() | 32'h0400_0000);
    chk(r_dat == 1'b1 && rdata[26] == 1'b1, "R9", {r_dat, rdata[26]}, 3);
    @(negedge clk);
    chk(r_dat == 1'b0 && rdata[26] == 1'b0, "R9", {r_dat, rdata[26]}, 0);
    run_to(2, 1, 0, 8, "R11");

    // R9: CMD reset
    wr(pack() | 32'h0200_0000);
    chk({r_all, r_cmd, r_dat} == 3'b010, "R9", {r_all, r_cmd, r_dat}, 2);
    chk(rdata[25] == 1'b1, "R9", rdata[25], 1);
    @(negedge clk);
    chk({r_all, r_cmd, r_dat, rdata[25]} == 4'b0, "R9",
        {r_all, r_cmd, r_dat, rdata[25]}, 0);

    // R10: reset-all clears clock fields
    s_int = 1; s_sd = 1; s_div = 8'h10; s_tmo = 4'd3;
    wr(pack());
    wr(pack() | 32'h0100_0000);
    chk(r_all == 1'b1, "R10", r_all, 1);
    chk(rdata[15:0] == 16'h0000, "R10", rdata[15:0], 0);
    chk(rdata[19:16] == 4'd3, "R10", rdata[19:16], 3);
    @(negedge clk);
    chk(r_all == 1'b0 && rdata[24] == 1'b0, "R9", {r_all, rdata[24]}, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule